// File: doc/BRIEF.md
# Serial-In Shift Register with Latched Tri-State Outputs

This block takes a serial bit stream on a shift clock and holds the assembled word in a separately clocked storage register, which drives a set of parallel pins that can be tri-stated. A serial data line and its clock, such as the data and clock pair of an SPI controller, connect directly to `ser_i` and `sclk_i`. A rising edge on `lclk_i` then moves the whole word to the pins in one step, so the pins never show a partly shifted value.

The last shift stage is brought out on `ser_o`. It can feed `ser_i` of another instance, so any number of instances can share one clock pair as a longer chain. The asynchronous reset clears only the shift stage. The values on the pins are kept. The output enable releases all parallel pins together. `par_oe_o` carries the per-pin drive enable for the pad cells.

Top module: `shift_latch_reg`

## Requirements
- R1: On each rising edge of `sclk_i` the shift stage moves one place toward its most significant bit, and `ser_i` enters bit 0. Bit 0 is the first stage and bit W-1 is the last, so a word sent most significant bit first ends up in its natural bit order.
- R2: `ser_o` always carries bit W-1 of the shift stage and is never high-impedance. It changes only on a rising `sclk_i` edge or on reset. `lclk_i` and `oe_ni` do not affect it.
- R3: A rising edge on `lclk_i` copies all W shift-stage bits into the storage register. Between latch edges the parallel outputs do not follow shifting.
- R4: When `sclk_i` and `lclk_i` rise at the same instant, the storage register takes the shift-stage contents from before that shift.
- R5: While `rst_ni` is low, the shift stage is cleared at once, with no clock edge needed, and `ser_o` reads 0. A latch edge after reset therefore stores all zeros.
- R6: Reset does not change the storage register. The parallel outputs keep their value through a reset pulse.
- R7: With `oe_ni` low, `par_o` equals the storage register and every bit of `par_oe_o` is 1. With `oe_ni` high, every bit of `par_o` is high-impedance and `par_oe_o` is all zeros.
- R8: With two instances chained (`ser_o` of the first feeding `ser_i` of the second, clocks shared), a 2W-bit word shifted most significant bit first and then latched puts its upper W bits on the second instance and its lower W bits on the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Shift clock, rising edge active |
| lclk_i | input | 1 | Storage (latch) clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low clear of the shift stage |
| ser_i | input | 1 | Serial data in |
| oe_ni | input | 1 | Active-low enable of the parallel outputs |
| par_o | output | W | Parallel outputs from the storage register, tri-stated when disabled |
| par_oe_o | output | W | Per-pin drive enable matching `par_o` |
| ser_o | output | 1 | Cascade output, last shift stage |

## Verification
The bench goes after the instant where both clocks rise together. A design that used the post-shift word would store a value shifted by one place. It also checks the parallel outputs between shifting and latching: a storage stage wired as transparent, or clocked by the shift clock, would show partly shifted values. A reset pulse after a latch must clear `ser_o` without any clock edge while leaving the pins alone; a reset wired to both stages would zero the pins. Toggling the latch clock and the enable must leave `ser_o` unchanged. A 16-bit chained transfer exposes a reversed shift direction or a cascade tap taken from the wrong stage, since either one swaps or scrambles the two bytes.

// File: rtl/slr_pkg.sv
package slr_pkg;
  localparam int unsigned SLR_W_DEF = 8;

  typedef enum logic {
    DRV_OFF = 1'b0,
    DRV_ON  = 1'b1
  } drv_e;
endpackage

// File: rtl/slr_shift_stage.sv
module slr_shift_stage #(
  parameter int unsigned W = 8
) (
  input  logic         sclk_i,
  input  logic         rst_ni,
  input  logic         ser_i,
  output logic [W-1:0] shift_o
);
  localparam int unsigned TOP = W - 1;

  logic [W-1:0] q;

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[TOP-1:0], ser_i};
  end

  assign shift_o = q;
endmodule

// File: rtl/slr_store_stage.sv
module slr_store_stage #(
  parameter int unsigned W = 8
) (
  input  logic         lclk_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // no reset: contents must survive the shift-stage clear
  always_ff @(posedge lclk_i) q_o <= d_i;
endmodule

// File: rtl/slr_pad_drv.sv
module slr_pad_drv
  import slr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         oe_ni,
  input  logic [W-1:0] d_i,
  output wire  [W-1:0] pad_o,
  output logic [W-1:0] en_o
);
  drv_e drv;
  assign drv = oe_ni ? DRV_OFF : DRV_ON;

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign en_o[i]  = (drv == DRV_ON);
    assign pad_o[i] = en_o[i] ? d_i[i] : 1'bz;
  end
endmodule

// File: rtl/shift_latch_reg.sv
module shift_latch_reg
  import slr_pkg::*;
#(
  parameter int unsigned W = SLR_W_DEF
) (
  input  logic         sclk_i,
  input  logic         lclk_i,
  input  logic         rst_ni,
  input  logic         ser_i,
  input  logic         oe_ni,
  output wire  [W-1:0] par_o,
  output logic [W-1:0] par_oe_o,
  output logic         ser_o
);
  localparam int unsigned TOP = W - 1;

  logic [W-1:0] shift_q;
  logic [W-1:0] store_q;

  slr_shift_stage #(.W(W)) u_shift (
    .sclk_i (sclk_i),
    .rst_ni (rst_ni),
    .ser_i  (ser_i),
    .shift_o(shift_q)
  );

  slr_store_stage #(.W(W)) u_store (
    .lclk_i(lclk_i),
    .d_i   (shift_q),
    .q_o   (store_q)
  );

  slr_pad_drv #(.W(W)) u_drv (
    .oe_ni(oe_ni),
    .d_i  (store_q),
    .pad_o(par_o),
    .en_o (par_oe_o)
  );

  assign ser_o = shift_q[TOP];
endmodule

// File: rtl/slr_checker.sv
module slr_checker #(
  parameter int unsigned W = 8
) (
  input logic         sclk_i,
  input logic         lclk_i,
  input logic         rst_ni,
  input logic         ser_i,
  input logic         oe_ni,
  input logic [W-1:0] shift_q,
  input logic [W-1:0] store_q,
  input logic [W-1:0] par_o,
  input logic [W-1:0] par_oe_o
);
  logic armed_s, armed_l;

  // set once a clock edge has been taken out of reset
  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) armed_s <= 1'b0;
    else         armed_s <= 1'b1;
  end

  always_ff @(posedge lclk_i or negedge rst_ni) begin
    if (!rst_ni) armed_l <= 1'b0;
    else         armed_l <= 1'b1;
  end

  AST_SHIFT_IN: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    armed_s |-> shift_q == {$past(shift_q[W-2:0]), $past(ser_i)})
    else $error("shift stage mismatch"); // R1

  AST_STORE_LOAD: assert property (@(posedge lclk_i) disable iff (!rst_ni)
    armed_l |-> store_q == $past(shift_q))
    else $error("storage load mismatch"); // R3

  AST_RST_CLEAR: assert property (@(posedge sclk_i)
    !rst_ni |-> shift_q == '0)
    else $error("shift stage not cleared"); // R5

  AST_PAR_DRIVE: assert property (@(posedge lclk_i) disable iff (!rst_ni)
    !oe_ni |-> (par_o == store_q) && (par_oe_o == {W{1'b1}}))
    else $error("parallel drive mismatch"); // R7
endmodule

bind shift_latch_reg slr_checker #(.W(W)) u_chk (
  .sclk_i  (sclk_i),
  .lclk_i  (lclk_i),
  .rst_ni  (rst_ni),
  .ser_i   (ser_i),
  .oe_ni   (oe_ni),
  .shift_q (shift_q),
  .store_q (store_q),
  .par_o   (par_o),
  .par_oe_o(par_oe_o)
);

// File: tb/sim_shift_latch_reg.sv
`timescale 1ns/1ps
module sim_shift_latch_reg;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic sclk = 1'b0, lclk = 1'b0, rst_n = 1'b1, ser = 1'b0, oe_n = 1'b1;
  wire  [7:0] par0, par1;
  logic [7:0] poe0, poe1;
  logic ser0, ser1;

  shift_latch_reg #(.W(8)) u0 (
    .sclk_i(sclk), .lclk_i(lclk), .rst_ni(rst_n), .ser_i(ser), .oe_ni(oe_n),
    .par_o(par0), .par_oe_o(poe0), .ser_o(ser0));

  shift_latch_reg #(.W(8)) u1 (
    .sclk_i(sclk), .lclk_i(lclk), .rst_ni(rst_n), .ser_i(ser0), .oe_ni(oe_n),
    .par_o(par1), .par_oe_o(poe1), .ser_o(ser1));

  typedef struct {
    logic [7:0] p0;
    logic [7:0] p1;
    logic       chk_p;
    logic       chk_p1;
    logic       oe;
    logic       s0;
    string      req;
  } item_t;

  item_t q_exp[$];
  event  mon_ev;
  int    checks = 0, errors = 0;
  logic  done = 1'b0;

  logic [15:0] mdl = '0;  // chain model: [7:0] u0, [15:8] u1
  logic [7:0]  st0, st1;

  // monitor: pop and compare
  always @(mon_ev) begin
    while (q_exp.size() > 0) begin
      item_t it;
      logic bad;
      it = q_exp.pop_front();
      bad = 1'b0;
      checks++;
      if (poe0 !== {8{it.oe}}) bad = 1'b1;
      if (ser0 !== it.s0) bad = 1'b1;
      if (it.chk_p && par0 !== it.p0) bad = 1'b1;
      if (it.chk_p1 && par1 !== it.p1) bad = 1'b1;
      if (bad) begin
        errors++;
        $display("FAIL %s: par0=%h par1=%h oe=%h ser0=%b exp par0=%h par1=%h oe=%b ser0=%b",
                 it.req, par0, par1, poe0, ser0, it.p0, it.p1, it.oe, it.s0);
      end
    end
  end

  task automatic expect_now(input string req, input logic cp, input logic [7:0] p0,
                            input logic cp1, input logic [7:0] p1);
    item_t it;
    @(negedge clk);
    it.p0 = p0; it.p1 = p1; it.chk_p = cp; it.chk_p1 = cp1;
    it.oe = ~oe_n; it.s0 = mdl[7]; it.req = req;
    q_exp.push_back(it);
    -> mon_ev;
    #0.1;
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk) ser = b;
    @(negedge clk) begin sclk = 1'b1; mdl = {mdl[14:0], b}; end
    @(negedge clk) sclk = 1'b0;
  endtask

  task automatic shift_word(input logic [15:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic latch();
    @(negedge clk) begin lclk = 1'b1; st0 = mdl[7:0]; st1 = mdl[15:8]; end
    @(negedge clk) lclk = 1'b0;
  endtask

  task automatic shift_and_latch(input logic b);
    @(negedge clk) ser = b;
    @(negedge clk) begin
      st0 = mdl[7:0]; st1 = mdl[15:8];
      sclk = 1'b1; lclk = 1'b1;
      mdl = {mdl[14:0], b};
    end
    @(negedge clk) begin sclk = 1'b0; lclk = 1'b0; end
  endtask

  initial begin
    #2 rst_n = 1'b0;
    mdl = '0;
    repeat (3) @(negedge clk);
    // R5 reset state, R7 released pins
    expect_now("R5", 1'b0, 8'h00, 1'b0, 8'h00);
    rst_n = 1'b1;

    // R1 R3 R7 known byte
    shift_word(16'h00A5, 8);
    latch();
    oe_n = 1'b0;
    expect_now("R1", 1'b1, 8'hA5, 1'b0, 8'h00);
    expect_now("R2", 1'b1, st0, 1'b0, 8'h00);

    // R3 no follow until latch edge
    shift_word(16'h003C, 8);
    expect_now("R3", 1'b1, 8'hA5, 1'b0, 8'h00);
    latch();
    expect_now("R3", 1'b1, 8'h3C, 1'b0, 8'h00);

    // R2 latch clock and enable leave ser_o alone
    shift_bit(1'b1);
    latch();
    expect_now("R2", 1'b1, 8'h79, 1'b0, 8'h00);
    oe_n = 1'b1;
    expect_now("R7", 1'b0, 8'h00, 1'b0, 8'h00);
    latch();
    expect_now("R2", 1'b0, 8'h00, 1'b0, 8'h00);
    oe_n = 1'b0;
    expect_now("R7", 1'b1, st0, 1'b0, 8'h00);

    // R4 simultaneous edges
    shift_word(16'h0096, 8);
    shift_and_latch(1'b1);
    expect_now("R4", 1'b1, 8'h96, 1'b0, 8'h00);
    latch();
    expect_now("R4", 1'b1, 8'h2D, 1'b0, 8'h00);

    // R5 R6 reset after latching
    shift_word(16'h00C3, 8);
    latch();
    expect_now("R6", 1'b1, 8'hC3, 1'b0, 8'h00);
    @(negedge clk) begin rst_n = 1'b0; mdl = '0; end
    expect_now("R5", 1'b1, 8'hC3, 1'b0, 8'h00);
    expect_now("R6", 1'b1, 8'hC3, 1'b0, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    latch();
    expect_now("R5", 1'b1, 8'h00, 1'b0, 8'h00);

    // R8 two-instance chain
    shift_word(16'hBEEF, 16);
    latch();
    expect_now("R8", 1'b1, 8'hEF, 1'b1, 8'hBE);
    shift_word(16'h1234, 16);
    expect_now("R8", 1'b1, 8'hEF, 1'b1, 8'hBE);
    latch();
    expect_now("R8", 1'b1, 8'h34, 1'b1, 8'h12);

    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule